// File: doc/BRIEF.md
# Multiplexed LCD Frame Sequencer

This block runs the digital side of a segment LCD that has up to four common lines. It counts a fast system clock down to a prescaled LCD clock and steps through the commons one at a time. Each common gets a slot made of two half-periods of opposite polarity, so every segment sees zero net DC. For each half-period the block selects the addressed common's slice of a shadow copy of the display image. It then emits a 2-bit level-select code for every common and segment pin, for the analog switches that connect each pin to one of four supply rails.

A drive-time code sets how long the level buffers stay enabled after each transition; after that the per-pin output enables drop and the pins float. The display image is a flat register bank copied once per frame, so writes made during a frame show up only in the next one. The number of commons is also taken only at frame boundaries. Nothing runs until the block is enabled and the supply-ready input is high. Every pin is a plain level, not a stream, because the image is sampled and not consumed. There is no valid/ready handshake and so no back-pressure.

Top module: `lcd_frame_seq`

## Requirements
- R1: While lcd_en or supply_ok was low at the previous clock edge (and during reset), every com_oe and seg_oe bit, every level code and frame_start are 0.
- R2: The first cycle of each frame has frame_start high for exactly one cycle. A frame first starts in the cycle after an edge at which lcd_en and supply_ok are both high. The frame begins with common 0 addressed in polarity 0.
- R3: Each half-period lasts PRESC clock cycles. A common's slot is polarity 0 and then polarity 1. Commons are addressed in the order 0, 1, … up to the duty code, and then the next frame starts at common 0.
- R4: The duty code d (d+1 commons) takes effect only at a frame start. Commons with an index above d have level code 0 and com_oe 0.
- R5: seg_data is copied at each frame start. Changes to it within a frame do not alter the outputs until the next frame.
- R6: While common k is addressed, segment j displays seg_data[k*NSEG + j]. With NSEG=40 this is bytes 5k to 5k+4, and a 1 means the segment is energized.
- R7: Level codes are 0 = ground, 1 = lower intermediate (also the only intermediate in half bias), 2 = upper intermediate and 3 = full. The addressed common is 0 in polarity 0 and 3 in polarity 1. The other used commons are 2 then 1 with bias_third=1, and 1 in both polarities with bias_third=0.
- R8: An energized segment is 3 in polarity 0 and 0 in polarity 1. A non-energized segment is 1 then 2 when d>0 and bias_third=1; otherwise it takes the addressed common's level (0 then 3).
- R9: In each half-period, output enables are high for the first W cycles and low for the rest. W = (PRESC/2·(c+1))/8 when d>0, and W = (PRESC·(c+1))/8 when d=0, where c is drive_code.
- R10: With d>0 no output enable stays high for more than PRESC/2 consecutive cycles within a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lcd_en | input | 1 | Sequencer enable |
| supply_ok | input | 1 | LCD supply has reached its target |
| duty | input | CW | Number of commons minus one |
| bias_third | input | 1 | 1 = one-third bias, 0 = half bias |
| drive_code | input | 3 | Buffer drive-time code |
| seg_data | input | NCOM*NSEG | Display image, one NSEG-bit slice per common |
| com_lvl | output | 2*NCOM | Level code per common pin |
| com_oe | output | NCOM | Buffer enable per common pin |
| seg_lvl | output | 2*NSEG | Level code per segment pin |
| seg_oe | output | NSEG | Buffer enable per segment pin |
| frame_start | output | 1 | One-cycle pulse at the first cycle of a frame |

## Verification
On every cycle the assertions check the following: the outputs are silent one cycle after the block is disabled or the supply drops, the frame pulse lasts one cycle, common 0 is at ground when a frame begins, unused commons float when only one common is used, and the multi-common enable window never passes half the LCD clock period. The exact level code of every pin, the slice order and the window length for each drive code are left to the bench's reference model. So are the deferral of image writes and duty changes to the next frame. Those depend on the order of stimulus across whole frames.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  typedef logic [1:0] lvl_t;

  localparam lvl_t LVL_GND  = 2'd0;
  localparam lvl_t LVL_LO   = 2'd1;
  localparam lvl_t LVL_HI   = 2'd2;
  localparam lvl_t LVL_FULL = 2'd3;

  // Level for a common pin that is in use.
  function automatic lvl_t com_level(input logic addressed, input logic pol,
                                     input logic bias_third);
    if (addressed) return pol ? LVL_FULL : LVL_GND;
    else if (bias_third) return pol ? LVL_LO : LVL_HI;
    else return LVL_LO;
  endfunction

  // Level for a segment pin; multi = more than one common in use.
  function automatic lvl_t seg_level(input logic on, input logic pol,
                                     input logic bias_third, input logic multi);
    if (on) return pol ? LVL_GND : LVL_FULL;
    else if (multi && bias_third) return pol ? LVL_HI : LVL_LO;
    else return pol ? LVL_FULL : LVL_GND;
  endfunction
endpackage

// File: rtl/lcd_timebase.sv
module lcd_timebase #(
  parameter int PRESC = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       multi,
  input  logic [2:0] drive_code,
  output logic       tick,
  output logic       div_zero,
  output logic       win_on
);
  localparam int DW   = $clog2(PRESC);
  localparam int HALF = PRESC / 2;

  logic [DW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else if (!go) div_q <= '0;
    else if (tick) div_q <= '0;
    else div_q <= div_q + 1'b1;
  end

  assign tick     = (int'(div_q) == PRESC - 1);
  assign div_zero = (div_q == '0);

  // Drive window: eighths of the half-period cap, or of the full period when static.
  int win_len;
  always_comb begin
    if (multi) win_len = (HALF * (int'(drive_code) + 1)) / 8;
    else       win_len = (PRESC * (int'(drive_code) + 1)) / 8;
    win_on = int'(div_q) < win_len;
  end
endmodule

// File: rtl/lcd_com_sequencer.sv
module lcd_com_sequencer #(
  parameter int NCOM = 4,
  parameter int NSEG = 40,
  parameter int CW   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_req,
  input  logic                 tick,
  input  logic                 div_zero,
  input  logic [CW-1:0]        duty,
  input  logic [NCOM*NSEG-1:0] seg_data,
  output logic                 running,
  output logic [CW-1:0]        com_idx,
  output logic                 pol,
  output logic [CW-1:0]        duty_act,
  output logic [NCOM*NSEG-1:0] shadow,
  output logic                 frame_start
);
  logic last_com;
  assign last_com = (com_idx == duty_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      com_idx  <= '0;
      pol      <= 1'b0;
      duty_act <= '0;
      shadow   <= '0;
    end else if (!run_req) begin
      running <= 1'b0;
      com_idx <= '0;
      pol     <= 1'b0;
    end else if (!running) begin
      running  <= 1'b1;
      com_idx  <= '0;
      pol      <= 1'b0;
      duty_act <= duty;
      shadow   <= seg_data;
    end else if (tick) begin
      pol <= ~pol;
      if (pol) begin
        if (last_com) begin
          com_idx  <= '0;
          duty_act <= duty;
          shadow   <= seg_data;
        end else begin
          com_idx <= com_idx + 1'b1;
        end
      end
    end
  end

  assign frame_start = running && div_zero && (com_idx == '0) && !pol;
endmodule

// File: rtl/lcd_level_encoder.sv
module lcd_level_encoder
  import lcd_seq_pkg::*;
#(
  parameter int NCOM = 4,
  parameter int NSEG = 40,
  parameter int CW   = 2
) (
  input  logic                 running,
  input  logic [CW-1:0]        com_idx,
  input  logic                 pol,
  input  logic [CW-1:0]        duty_act,
  input  logic                 bias_third,
  input  logic                 win_on,
  input  logic [NCOM*NSEG-1:0] shadow,
  output logic [2*NCOM-1:0]    com_lvl,
  output logic [NCOM-1:0]      com_oe,
  output logic [2*NSEG-1:0]    seg_lvl,
  output logic [NSEG-1:0]      seg_oe
);
  logic            multi;
  logic [NSEG-1:0] slice;

  assign multi = (duty_act != '0);

  always_comb begin
    int base;
    base  = int'(com_idx) * NSEG;
    slice = shadow[base +: NSEG];
  end

  for (genvar k = 0; k < NCOM; k++) begin : g_com
    logic used;
    assign used = running && (int'(duty_act) >= k);
    assign com_lvl[2*k +: 2] = used ? com_level(com_idx == CW'(k), pol, bias_third) : LVL_GND;
    assign com_oe[k] = used && win_on;
  end

  for (genvar j = 0; j < NSEG; j++) begin : g_seg
    assign seg_lvl[2*j +: 2] = running ? seg_level(slice[j], pol, bias_third, multi) : LVL_GND;
    assign seg_oe[j] = running && win_on;
  end
endmodule

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq #(
  parameter int NCOM  = 4,
  parameter int NSEG  = 40,
  parameter int PRESC = 64,
  parameter int CW    = (NCOM > 1) ? $clog2(NCOM) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lcd_en,
  input  logic                 supply_ok,
  input  logic [CW-1:0]        duty,
  input  logic                 bias_third,
  input  logic [2:0]           drive_code,
  input  logic [NCOM*NSEG-1:0] seg_data,
  output logic [2*NCOM-1:0]    com_lvl,
  output logic [NCOM-1:0]      com_oe,
  output logic [2*NSEG-1:0]    seg_lvl,
  output logic [NSEG-1:0]      seg_oe,
  output logic                 frame_start
);
  logic                 run_req, running, tick, div_zero, win_on, pol;
  logic [CW-1:0]        com_idx, duty_act;
  logic [NCOM*NSEG-1:0] shadow;

  assign run_req = lcd_en && supply_ok;

  lcd_timebase #(.PRESC(PRESC)) u_tb (
    .clk(clk), .rst_n(rst_n), .go(running && run_req),
    .multi(duty_act != '0), .drive_code(drive_code),
    .tick(tick), .div_zero(div_zero), .win_on(win_on)
  );

  lcd_com_sequencer #(.NCOM(NCOM), .NSEG(NSEG), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .run_req(run_req), .tick(tick),
    .div_zero(div_zero), .duty(duty), .seg_data(seg_data),
    .running(running), .com_idx(com_idx), .pol(pol),
    .duty_act(duty_act), .shadow(shadow), .frame_start(frame_start)
  );

  lcd_level_encoder #(.NCOM(NCOM), .NSEG(NSEG), .CW(CW)) u_enc (
    .running(running), .com_idx(com_idx), .pol(pol), .duty_act(duty_act),
    .bias_third(bias_third), .win_on(win_on), .shadow(shadow),
    .com_lvl(com_lvl), .com_oe(com_oe), .seg_lvl(seg_lvl), .seg_oe(seg_oe)
  );
endmodule

// File: rtl/lcd_frame_seq_chk.sv
module lcd_frame_seq_chk #(
  parameter int NCOM  = 4,
  parameter int NSEG  = 40,
  parameter int PRESC = 64,
  parameter int CW    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lcd_en,
  input logic              supply_ok,
  input logic              frame_start,
  input logic [2*NCOM-1:0] com_lvl,
  input logic [NCOM-1:0]   com_oe,
  input logic [NSEG-1:0]   seg_oe,
  input logic [CW-1:0]     duty_act
);
  localparam int HALF = PRESC / 2;

  int oe_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_run <= 0;
    else if (!seg_oe[0]) oe_run <= 0;
    else if (frame_start) oe_run <= 1;
    else if (oe_run <= HALF) oe_run <= oe_run + 1;
  end

  // R1
  inhibit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lcd_en && supply_ok) |=> (com_oe == '0 && seg_oe == '0 && !frame_start));

  // R2
  frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  // R7
  frame_com0_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (com_lvl[1:0] == 2'd0 && com_oe[0]));

  // R10
  window_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act != '0 && seg_oe[0] && !frame_start) |-> (oe_run < HALF));

  if (NCOM > 1) begin : g_unused
    // R4
    static_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_act == '0) |-> (com_oe[NCOM-1:1] == '0));
  end
endmodule

bind lcd_frame_seq lcd_frame_seq_chk #(.NCOM(NCOM), .NSEG(NSEG), .PRESC(PRESC), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lcd_en(lcd_en), .supply_ok(supply_ok),
  .frame_start(frame_start), .com_lvl(com_lvl), .com_oe(com_oe),
  .seg_oe(seg_oe), .duty_act(duty_act)
);

// File: tb/sim_lcd_frame_seq.sv
`timescale 1ns/1ps
module sim_lcd_frame_seq;
  localparam int NCOM = 4, NSEG = 40, PRESC = 16, CW = 2;

  logic clk = 1'b0, rst_n = 1'b0, lcd_en = 1'b0, supply_ok = 1'b0, bias_third = 1'b1;
  logic [CW-1:0] duty = '0;
  logic [2:0] drive_code = 3'd7;
  logic [NCOM*NSEG-1:0] seg_data = '0;
  logic [2*NCOM-1:0] com_lvl;
  logic [NCOM-1:0] com_oe;
  logic [2*NSEG-1:0] seg_lvl;
  logic [NSEG-1:0] seg_oe;
  logic frame_start;

  lcd_frame_seq #(.NCOM(NCOM), .NSEG(NSEG), .PRESC(PRESC)) u0 (
    .clk(clk), .rst_n(rst_n), .lcd_en(lcd_en), .supply_ok(supply_ok), .duty(duty),
    .bias_third(bias_third), .drive_code(drive_code), .seg_data(seg_data),
    .com_lvl(com_lvl), .com_oe(com_oe), .seg_lvl(seg_lvl), .seg_oe(seg_oe),
    .frame_start(frame_start));

  always #5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  // Behavioural reference state
  bit m_run; int m_div, m_com, m_pol, m_duty;
  logic [NCOM*NSEG-1:0] m_img;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_div = 0; m_com = 0; m_pol = 0; m_duty = 0; m_img = '0;
    end else if (!(lcd_en && supply_ok)) begin
      m_run = 0; m_div = 0; m_com = 0; m_pol = 0;
    end else if (!m_run) begin
      m_run = 1; m_div = 0; m_com = 0; m_pol = 0; m_duty = int'(duty); m_img = seg_data;
    end else if (m_div == PRESC - 1) begin
      m_div = 0;
      if (m_pol == 0) m_pol = 1;
      else begin
        m_pol = 0;
        if (m_com == m_duty) begin m_com = 0; m_duty = int'(duty); m_img = seg_data; end
        else m_com = m_com + 1;
      end
    end else m_div = m_div + 1;
  end

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // Compare all outputs with the model on every cycle, between edges.
  always @(negedge clk) begin
    logic [2*NCOM-1:0] e_cl; logic [NCOM-1:0] e_co;
    logic [2*NSEG-1:0] e_sl; logic [NSEG-1:0] e_so;
    int win; bit on;
    #2;
    win = (m_duty > 0) ? ((PRESC / 2) * (int'(drive_code) + 1)) / 8
                       : (PRESC * (int'(drive_code) + 1)) / 8;
    on = m_run && (m_div < win);
    for (int k = 0; k < NCOM; k++) begin
      if (!m_run || k > m_duty) begin e_cl[2*k +: 2] = 2'd0; e_co[k] = 1'b0; end
      else begin
        e_co[k] = on;
        if (k == m_com) e_cl[2*k +: 2] = m_pol ? 2'd3 : 2'd0;
        else if (bias_third) e_cl[2*k +: 2] = m_pol ? 2'd1 : 2'd2;
        else e_cl[2*k +: 2] = 2'd1;
      end
    end
    for (int j = 0; j < NSEG; j++) begin
      e_so[j] = on;
      if (!m_run) e_sl[2*j +: 2] = 2'd0;
      else if (m_img[m_com*NSEG + j]) e_sl[2*j +: 2] = m_pol ? 2'd0 : 2'd3;
      else if (m_duty > 0 && bias_third) e_sl[2*j +: 2] = m_pol ? 2'd2 : 2'd1;
      else e_sl[2*j +: 2] = m_pol ? 2'd3 : 2'd0;
    end
    check("R2 frame_start", 128'(frame_start), 128'(m_run && m_div == 0 && m_com == 0 && m_pol == 0));
    check("R3 R7 com_lvl", 128'(com_lvl), 128'(e_cl));
    check("R4 R9 com_oe", 128'(com_oe), 128'(e_co));
    check("R5 R6 R8 seg_lvl", 128'(seg_lvl), 128'(e_sl));
    check("R9 R10 seg_oe", 128'(seg_oe), 128'(e_so));
    cyc++;
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic quiet_check(input string tag);
    #3;
    check(tag, 128'({com_oe, seg_oe, frame_start, com_lvl, seg_lvl}), 128'(0));
  endtask

  initial begin
    wait_cyc(3);
    quiet_check("R1 reset outputs");
    rst_n = 1'b1;
    lcd_en = 1'b1;
    wait_cyc(20);
    quiet_check("R1 supply not ready");
    // One-third bias, four commons, widest window.
    duty = 2'd3; bias_third = 1'b1; drive_code = 3'd7;
    seg_data = {5{32'hA5C3_1E7B}};
    supply_ok = 1'b1;
    wait_cyc(1);
    #3 check("R2 first frame pulse", 128'(frame_start), 128'(1));
    wait_cyc(40);
    seg_data = {5{32'h0F0F_96E1}};          // R5 mid-frame write
    duty = 2'd1;                           // R4 mid-frame duty change
    wait_cyc(200);
    drive_code = 3'd0;
    wait_cyc(70);
    bias_third = 1'b0; drive_code = 3'd3;  // half bias
    seg_data = ~seg_data;
    wait_cyc(140);
    duty = 2'd0; drive_code = 3'd7;         // static drive, always enabled
    wait_cyc(120);
    drive_code = 3'd2;
    seg_data = {5{32'h1234_5678}};
    wait_cyc(80);
    duty = 2'd2; bias_third = 1'b1; drive_code = 3'd5;
    wait_cyc(150);
    supply_ok = 1'b0;                      // supply drops mid-frame
    wait_cyc(1);
    quiet_check("R1 supply dropped");
    wait_cyc(10);
    supply_ok = 1'b1; duty = 2'd3; drive_code = 3'd6;
    seg_data = {5{32'hDEAD_0001}};
    wait_cyc(300);
    lcd_en = 1'b0;
    wait_cyc(2);
    quiet_check("R1 disabled");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule